// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block lets the cores of a small multiprocessor interrupt one another. Each core holds two pending flags, one for an IPI sent by another core ("other") and one for an IPI it sent to itself ("self"). Each core also holds a two-bit mask. A core's interrupt request output is high while it has at least one IPI that is pending and not masked.

All accesses go through one single-cycle register port. A core-id input names the core making the access, and every acknowledge, mask or reason access works on that core's own state. A send can reach any core.

Reading the reason register reports the highest-priority live IPI and masks it in the same access, so the request output drops at once. The flag stays pending until software acknowledges it. If software unmasks the IPI without acknowledging it, the request comes back.

Top module: `ipi_unit`

Register offsets (word index on `req_addr`): 0 reason (read), 1 send (write), 2 acknowledge (write), 3 mask set, 4 mask clear. Offsets 5 to 7 are unused.

## Requirements
- R1: After reset, no IPI is pending, both mask bits of every core are 0, every `irq_o` bit is low and `rdata_o` is 0.
- R2: A write to the send offset with bit n set, for n below NCORES, makes the "other" IPI of core n pending. Bits from NCORES to 30 have no effect.
- R3: A write to the send offset with bit 31 set makes the "self" IPI of the accessing core pending.
- R4: A write to the acknowledge offset clears the accessing core's pending "other" IPI when bit 0 is 1, and its pending "self" IPI when bit 31 is 1. No other core's state changes.
- R5: A write to the mask set offset sets, and a write to the mask clear offset clears, the accessing core's mask bits. Bit 0 is the "other" mask and bit 31 is the "self" mask. A read of either offset returns the mask in those bit positions, with 0 in all other bits.
- R6: `irq_o[c]` is high exactly when core c has an IPI that is both pending and unmasked. It follows a write in the cycle after that write.
- R7: A read of the reason offset returns one of three values. It is 0 when nothing is both pending and unmasked. It is 32'h0002_0001 when the "self" IPI is live, which takes priority over "other". It is 32'h0002_0000 when only the "other" IPI is live.
- R8: A read of the reason offset that reports an IPI sets that IPI's mask bit. It leaves the pending state unchanged.
- R9: Clearing the mask of an IPI that is still pending raises `irq_o` again.
- R10: Reads of the send offset, the acknowledge offset and the unused offsets return 0. Writes to the reason offset and the unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_core | input | CORE_W | Index of the accessing core |
| req_addr | input | 3 | Register word offset |
| req_wdata | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | NCORES | Interrupt request, one bit per core |

## Verification
Every effect of an access is registered once. The state change, the new `irq_o` level and the read data all appear in the cycle after the edge that takes the access. The bench drives each access on a falling edge, lets one rising edge capture it, and samples `rdata_o` and all `irq_o` bits at the next falling edge. It then compares them with a model that it updates in the same step. A reason read is followed at that same falling edge by the check of the masked request. The random mix of sends, acknowledges, mask writes and reason reads keeps this one-cycle rule throughout.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        OFS_REASON = 3'd0,
        OFS_SEND   = 3'd1,
        OFS_ACK    = 3'd2,
        OFS_MSET   = 3'd3,
        OFS_MCLR   = 3'd4
    } ofs_e;

    localparam logic [15:0] REASON_KIND_IPI = 16'h0002;
    localparam int          SELF_BIT        = 31;

    // index 0: other, index 1: self
    typedef struct packed {
        logic [1:0] pend;
        logic [1:0] mask;
    } slice_t;

endpackage

// File: rtl/ipi_slice.sv
module ipi_slice
    import ipi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] post_i,
    input  logic [1:0] ack_i,
    input  logic [1:0] mset_i,
    input  logic [1:0] mclr_i,
    input  logic [1:0] take_i,
    output logic [1:0] pend_o,
    output logic [1:0] mask_o,
    output logic       irq_o
);

    slice_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~ack_i) | post_i;
        st_d.mask = (st_q.mask | mset_i | take_i) & ~mclr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.pend & ~st_q.mask);

    // R2
    post_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_i[0] |=> pend_o[0]);
    // R3
    post_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_i[1] |=> pend_o[1]);
    // R4
    ack_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[0] && !post_i[0]) |=> !pend_o[0]);
    // R8
    take_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i != 2'b00 && ack_i == 2'b00 && post_i == 2'b00 && mclr_i == 2'b00)
        |=> ((mask_o & $past(take_i)) == $past(take_i)) && $stable(pend_o));
    // R9
    unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mclr_i != 2'b00 && (pend_o & mclr_i) != 2'b00 && ack_i == 2'b00) |=> irq_o);

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CORE_W-1:0] req_core,
    input  logic [2:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rdata_o,
    output logic [NCORES-1:0] irq_o
);

    typedef struct packed {
        logic [31:0] rdata;
    } top_t;

    top_t top_d, top_q;

    logic [NCORES-1:0][1:0] pend, mask, post, ack, mset, mclr, take;
    logic [1:0]             cur_pend, cur_mask, cur_live;
    logic                   any_wr;

    assign any_wr = req_valid && req_write && (int'(req_core) < NCORES);

    always_comb begin
        cur_pend = '0;
        cur_mask = '0;
        for (int c = 0; c < NCORES; c++) begin
            if (int'(req_core) == c) begin
                cur_pend = pend[c];
                cur_mask = mask[c];
            end
        end
        cur_live = cur_pend & ~cur_mask;
    end

    always_comb begin
        for (int c = 0; c < NCORES; c++) begin
            logic mine, wr, rd;
            mine = req_valid && (int'(req_core) == c);
            wr   = mine && req_write;
            rd   = mine && !req_write;
            post[c][0] = any_wr && (req_addr == OFS_SEND) && req_wdata[c];
            post[c][1] = wr && (req_addr == OFS_SEND) && req_wdata[SELF_BIT];
            ack[c]     = (wr && req_addr == OFS_ACK)  ? {req_wdata[SELF_BIT], req_wdata[0]} : 2'b00;
            mset[c]    = (wr && req_addr == OFS_MSET) ? {req_wdata[SELF_BIT], req_wdata[0]} : 2'b00;
            mclr[c]    = (wr && req_addr == OFS_MCLR) ? {req_wdata[SELF_BIT], req_wdata[0]} : 2'b00;
            take[c]    = 2'b00;
            if (rd && req_addr == OFS_REASON) begin
                if (cur_live[1])      take[c] = 2'b10;
                else if (cur_live[0]) take[c] = 2'b01;
            end
        end
    end

    always_comb begin
        top_d.rdata = '0;
        if (req_valid && !req_write && int'(req_core) < NCORES) begin
            case (req_addr)
                OFS_REASON: begin
                    if (cur_live[1])      top_d.rdata = {REASON_KIND_IPI, 16'd1};
                    else if (cur_live[0]) top_d.rdata = {REASON_KIND_IPI, 16'd0};
                end
                OFS_MSET, OFS_MCLR: top_d.rdata = {cur_mask[1], 30'd0, cur_mask[0]};
                default: top_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rdata_o = top_q.rdata;

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        ipi_slice u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .post_i (post[g]),
            .ack_i  (ack[g]),
            .mset_i (mset[g]),
            .mclr_i (mclr[g]),
            .take_i (take[g]),
            .pend_o (pend[g]),
            .mask_o (mask[g]),
            .irq_o  (irq_o[g])
        );
    end

    // R7
    reason_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFS_REASON && cur_live == 2'b00) |=> rdata_o == 32'd0);
    // R10
    wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr == OFS_SEND || req_addr == OFS_ACK)) |=> rdata_o == 32'd0);
    // R8
    reason_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == OFS_REASON && cur_live == 2'b10) |=> !irq_o[$past(req_core)]);

endmodule

// File: tb/sim_ipi_unit.sv
module sim_ipi_unit;

    localparam int N  = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [CW-1:0] req_core = '0;
    logic [2:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rdata_o;
    logic [N-1:0]  irq_o;

    int errors = 0, checks = 0;
    logic [1:0] pend_m [N];
    logic [1:0] mask_m [N];

    always #5 clk = ~clk;

    ipi_unit #(.NCORES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] reason_of(int c);
        logic [1:0] live = pend_m[c] & ~mask_m[c];
        if (live[1]) return 32'h0002_0001;
        if (live[0]) return 32'h0002_0000;
        return 32'd0;
    endfunction

    function automatic logic [N-1:0] irq_exp();
        logic [N-1:0] v;
        for (int c = 0; c < N; c++) v[c] = |(pend_m[c] & ~mask_m[c]);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access: drive at falling edge, captured at rising edge, sampled at next falling edge
    task automatic access(input int core, input bit wr, input int addr, input logic [31:0] data, input string req);
        logic [31:0] exp_rd = 32'd0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_core = CW'(core);
        req_addr = 3'(addr); req_wdata = data;
        if (!wr) begin
            if (addr == 0) begin
                exp_rd = reason_of(core);
                if (exp_rd == 32'h0002_0001) mask_m[core][1] = 1'b1;
                else if (exp_rd == 32'h0002_0000) mask_m[core][0] = 1'b1;
            end else if (addr == 3 || addr == 4) begin
                exp_rd = {mask_m[core][1], 30'd0, mask_m[core][0]};
            end
        end else begin
            case (addr)
                1: begin
                    for (int c = 0; c < N; c++) if (data[c]) pend_m[c][0] = 1'b1;
                    if (data[31]) pend_m[core][1] = 1'b1;
                end
                2: pend_m[core] = pend_m[core] & ~{data[31], data[0]};
                3: mask_m[core] = mask_m[core] | {data[31], data[0]};
                4: mask_m[core] = mask_m[core] & ~{data[31], data[0]};
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr) chk(rdata_o == exp_rd, req, rdata_o, exp_rd);
        chk(irq_o == irq_exp(), {req, "/R6 irq"}, 32'(irq_o), 32'(irq_exp()));
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed = 11;
        void'($urandom(seed));
        for (int c = 0; c < N; c++) begin pend_m[c] = '0; mask_m[c] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(irq_o == '0, "R1 irq", 32'(irq_o), 0);
        chk(rdata_o == 0, "R1 rdata", rdata_o, 0);
        rst_n = 1'b1;
        access(0, 0, 3, 0, "R1 mask");
        access(2, 0, 0, 0, "R7 idle reason");
        // R2 send other, high bits ignored
        access(1, 1, 1, 32'h7FFF_FFF4, "R2 send");
        access(2, 0, 0, 0, "R7 other reason");
        access(2, 0, 3, 0, "R8 mask after reason");
        access(2, 1, 4, 32'h0000_0001, "R9 unmask");
        // R3 self, priority over other
        access(2, 1, 1, 32'h8000_0000, "R3 self");
        access(2, 0, 0, 0, "R7 self priority");
        access(2, 0, 0, 0, "R7 then other");
        access(2, 1, 2, 32'h8000_0001, "R4 ack both");
        access(2, 1, 4, 32'h8000_0001, "R4 unmask after ack");
        // R10 write-only / unused reads, writes to reason
        access(0, 0, 1, 0, "R10 send read");
        access(0, 0, 2, 0, "R10 ack read");
        access(0, 0, 6, 0, "R10 unused read");
        access(3, 1, 0, 32'hFFFF_FFFF, "R10 reason write");
        access(3, 1, 7, 32'hFFFF_FFFF, "R10 unused write");
        access(3, 0, 3, 0, "R10 mask intact");
        // R5 mask set/clear readback
        access(3, 1, 3, 32'h8000_0001, "R5 set");
        access(3, 0, 4, 0, "R5 read clr addr");
        access(3, 1, 4, 32'h0000_0001, "R5 clear");
        access(3, 0, 3, 0, "R5 read set addr");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            int core = $urandom_range(0, N - 1);
            logic [31:0] d = $urandom();
            if ($urandom_range(0, 1) == 1) d = d & 32'h8000_000F;
            case (op)
                0, 1:    access(core, 1, 1, d, "R2/R3 rand send");
                2:       access(core, 1, 2, d, "R4 rand ack");
                3:       access(core, 1, 3, d, "R5 rand mset");
                4:       access(core, 1, 4, d, "R9 rand mclr");
                5, 6:    access(core, 0, 0, 0, "R7/R8 rand reason");
                7:       access(core, 0, $urandom_range(3, 4), 0, "R5 rand mread");
                8:       access(core, 0, $urandom_range(1, 7), 0, "R10 rand read");
                default: access(core, 1, $urandom_range(5, 7), d, "R10 rand unused write");
            endcase
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule